// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter with Carry and Borrow

This block is a small binary counter that is moved by two separate strobe inputs rather than by one clock and a direction bit. A rising edge on the increment strobe adds one to the value. A rising edge on the decrement strobe subtracts one. A strobe that is not in use rests HIGH. The block also takes a parallel value through an active-low load input and has an active-high clear. It drives two active-low terminal-count outputs so that several stages can be chained: the carry output feeds the next stage's increment strobe and the borrow output feeds its decrement strobe.

The whole block runs in one system-clock domain. Each strobe passes through a two-flop synchronizer. A rising edge is taken to be a synchronized sample of 1 whose previous sample was 0, and that edge gives a one-cycle count enable. Clear and load act on the next system clock edge no matter what the strobes are doing. If both strobes rise in the same cycle, the value holds and a sticky collision flag is raised.

Top module: `updn_strobe_counter`

## Requirements
- R1: After reset, with both strobes HIGH, `count` is 0, `carry_n` and `borrow_n` are 1, and `collide` is 0.
- R2: A rising edge on `inc_stb`, with no load or clear active, increases `count` by one. The value wraps from 15 back to 0.
- R3: A rising edge on `dec_stb`, with no load or clear active, decreases `count` by one. The value wraps from 0 up to 15.
- R4: `clr` is active HIGH. It forces `count` to 0 and clears `collide`, and it takes priority over load and over both strobes.
- R5: `load_n` is active LOW. While it is LOW, `din` is copied into `count`, and any strobe edge that arrives in that time is discarded.
- R6: `carry_n` is 0 exactly when `count` is 15 and the synchronized `inc_stb` is LOW. Otherwise it is 1.
- R7: `borrow_n` is 0 exactly when `count` is 0 and the synchronized `dec_stb` is LOW. Otherwise it is 1.
- R8: If both strobes rise in the same system cycle, `count` holds and `collide` becomes 1. `collide` stays at 1 until `clr` is asserted; load and later counting do not clear it.
- R9: A strobe edge driven between clock edges changes `count` on the third rising clock edge after it, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Active-high clear of the count and of the collision flag |
| load_n | input | 1 | Active-low parallel load |
| din | input | WIDTH | Value for the parallel load |
| inc_stb | input | 1 | Increment strobe; rests HIGH, counts on its rising edge |
| dec_stb | input | 1 | Decrement strobe; rests HIGH, counts on its rising edge |
| count | output | WIDTH | Current count value |
| carry_n | output | 1 | Active-low terminal count for counting up |
| borrow_n | output | 1 | Active-low terminal count for counting down |
| collide | output | 1 | Sticky flag: both strobes rose in the same cycle |

## Verification
The bench loads every value from 0 to 15 and steps it once up and once down, so both wraparounds are covered. A design with a wrong modulus or a wrong step direction would fail one of these steps. Carry and borrow are driven with the strobe both LOW and HIGH at the terminal values and at an ordinary value. Gating on the wrong strobe, or on count alone, would show up as an output that goes low at the wrong time. The bench also raises a strobe edge in the middle of a load, raises both strobes in the same cycle, and applies clear together with load. A design that lets an edge through during load, counts on a collision, drops the sticky flag, or ranks load above clear would show a wrong count or a wrong flag. A check one cycle before the expected update catches a synchronizer that is too short.

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             inc_stb,
  input  logic             dec_stb,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n,
  output logic             collide
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic [2:0] inc_q, dec_q;
  logic       inc_rise, dec_rise, hold_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= 3'b111;
      dec_q <= 3'b111;
    end else begin
      inc_q <= {inc_q[1:0], inc_stb};
      dec_q <= {dec_q[1:0], dec_stb};
    end
  end

  assign inc_rise = inc_q[1] & ~inc_q[2];
  assign dec_rise = dec_q[1] & ~dec_q[2];
  assign hold_off = clr | ~load_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      collide <= 1'b0;
    end else if (clr) begin
      count   <= '0;
      collide <= 1'b0;
    end else if (!load_n) begin
      count <= din;
    end else if (inc_rise && dec_rise) begin
      collide <= 1'b1;
    end else if (inc_rise) begin
      count <= count + 1'b1;
    end else if (dec_rise) begin
      count <= count - 1'b1;
    end
  end

  assign carry_n  = ~((count == TOP) & ~inc_q[1]);
  assign borrow_n = ~((count == '0)  & ~dec_q[1]);

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !collide));

  assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> (count == $past(din)));

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_off && inc_rise && !dec_rise) |=> (count == $past(count) + 1'b1));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_off && dec_rise && !inc_rise) |=> (count == $past(count) - 1'b1));

  assert_collide_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_off && inc_rise && dec_rise) |=> ($stable(count) && collide));

  assert_collide_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !clr) |=> collide);

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_off && !inc_rise && !dec_rise) |=> $stable(count));

endmodule

// File: tb/updn_strobe_counter_tb.sv
module updn_strobe_counter_tb_top;
  localparam int W = 4;
  logic clk = 0, rst_n = 0, clr = 0, load_n = 1, inc_stb = 1, dec_stb = 1;
  logic [W-1:0] din = '0;
  logic [W-1:0] count;
  logic carry_n, borrow_n, collide;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  updn_strobe_counter #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
    .inc_stb(inc_stb), .dec_stb(dec_stb), .count(count),
    .carry_n(carry_n), .borrow_n(borrow_n), .collide(collide));

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(int v);
    din = W'(v); load_n = 0; cyc(2); load_n = 1; cyc(1);
  endtask

  task automatic pulse_up();
    inc_stb = 0; cyc(3); inc_stb = 1; cyc(4);
  endtask

  task automatic pulse_dn();
    dec_stb = 0; cyc(3); dec_stb = 1; cyc(4);
  endtask

  initial begin
    cyc(2); rst_n = 1; cyc(2);
    chk("R1 count", count, 0);
    chk("R1 carry_n", carry_n, 1);
    chk("R1 borrow_n", borrow_n, 1);
    chk("R1 collide", collide, 0);

    for (int v = 0; v < 16; v++) begin
      do_load(v);
      chk("R5 load", count, v);
      pulse_up();
      chk("R2 up step", count, (v + 1) % 16);
      do_load(v);
      pulse_dn();
      chk("R3 down step", count, (v + 15) % 16);
    end

    do_load(0);
    for (int i = 1; i <= 20; i++) begin
      pulse_up();
      chk("R2 run", count, i % 16);
    end

    do_load(15);
    inc_stb = 0; cyc(3);
    chk("R6 carry low", carry_n, 0);
    chk("R7 borrow idle", borrow_n, 1);
    inc_stb = 1; cyc(4);
    chk("R6 carry released", carry_n, 1);
    chk("R2 wrap", count, 0);

    do_load(7);
    inc_stb = 0; dec_stb = 1; cyc(3);
    chk("R6 carry not at 7", carry_n, 1);
    inc_stb = 1; cyc(4);

    do_load(15);
    cyc(3);
    chk("R6 carry strobe high", carry_n, 1);

    do_load(0);
    dec_stb = 0; cyc(3);
    chk("R7 borrow low", borrow_n, 0);
    chk("R6 carry idle", carry_n, 1);
    dec_stb = 1; cyc(4);
    chk("R7 borrow released", borrow_n, 1);
    chk("R3 wrap", count, 15);

    do_load(3);
    inc_stb = 0; cyc(3); inc_stb = 1; cyc(2);
    chk("R9 not before third edge", count, 3);
    cyc(1);
    chk("R9 at third edge", count, 4);
    cyc(3);

    din = 4'd5; load_n = 0; inc_stb = 0; cyc(3); inc_stb = 1; cyc(4);
    load_n = 1; cyc(4);
    chk("R5 edge during load ignored", count, 5);

    do_load(9);
    inc_stb = 0; dec_stb = 0; cyc(3);
    inc_stb = 1; dec_stb = 1; cyc(4);
    chk("R8 hold", count, 9);
    chk("R8 flag", collide, 1);
    pulse_up();
    chk("R8 count after", count, 10);
    chk("R8 sticky count", collide, 1);
    do_load(2);
    chk("R8 sticky load", collide, 1);

    din = 4'd9; load_n = 0; clr = 1; cyc(2);
    chk("R4 clear over load", count, 0);
    chk("R4 flag cleared", collide, 0);
    clr = 0; load_n = 1; cyc(2);
    chk("R4 stays zero", count, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule